// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one 8-bit pulse-width modulation channel. A small register port gives access to four registers: control, period, duty and counter. A channel tick input marks each step of the channel clock; it comes from a prescaler outside this block. The counter steps once per tick. While the counter is below the duty threshold, the output sits at the level the polarity bit selects, and it takes the opposite level for the rest of the period. Two alignment modes are available. In the edge-aligned mode the counter only counts upward. In the center-aligned mode it counts up and then back down, so a period takes twice as many ticks.

Period and duty each have two copies: a shadow that software writes and an active copy that the waveform uses. While the channel runs, a write lands only in the shadow. The active copy picks it up at one of three points: the end of a period, a counter restart, or while the channel is disabled. Each waveform period is therefore built entirely from one pair of values. Reads always return the shadow.

The register port is not a stream. It is a plain single-cycle write strobe with a combinational read mux, so it has no valid/ready handshake and no back-pressure. A parameter can mark the channel as absent. An absent channel ignores writes, reads as zero and holds its output low.

Top module: `pwm_channel`

## Requirements
- R1: In edge-aligned mode (control bit 1 = 0) with active period P > 0, the counter steps 0..P-1 on successive ticks and then returns to 0, so one output period is P ticks.
- R2: In center-aligned mode (control bit 1 = 1) with P > 0, the counter steps 0..P while rising and then P-1..0 while falling, so one output period is 2P ticks and the counter never exceeds P.
- R3: While enabled, the output is at the polarity level when the counter is below the active duty D (rising phase) or at most D (falling phase), and at the opposite level otherwise. In edge-aligned mode it therefore changes only where the counter equals D or returns to 0.
- R4: A period or duty write made while the channel is enabled (control bit 0 = 1) changes only the shadow. The active copy takes the shadow only at a period end, at a counter restart, or while disabled.
- R5: Any write to the counter register (select 3) forces the counter to 0 whatever the data. Writing the control register with enable kept at 1 and a different alignment bit restarts the counter in the same way.
- R6: A period or duty write made while the channel is disabled updates the shadow and the active copy together.
- R7: Reading the period (select 1) or duty (select 2) returns the last value written, even when the active copy still holds an older value. Select 0 reads control as {0, pol, center, en}, and select 3 reads the counter.
- R8: With PRESENT = 0, every register reads 0, writes have no effect and the output stays low.
- R9: An active period of 0 holds the output at the polarity level, and each tick then counts as a period end.
- R10: A duty greater than or equal to the period holds the output at the polarity level for the whole period. A duty of 0 holds it at the opposite level.
- R11: While disabled, the counter is held at 0 and the output sits at the polarity level.
- R12: The polarity bit (control bit 2) set to 1 makes the first part of each period high; set to 0, it makes it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Channel clock enable, one pulse per counter step |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 counter |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded properties check several things on every clock. They confirm that the counter stays within its range in both modes and returns to 0 after a restart or while disabled. They confirm that active values change only at the allowed load points, and that a disabled channel keeps its active copies equal to the shadows. In edge-aligned mode they confirm that the output changes only at the duty match or at the wrap. The bench scenarios cover what a single-cycle property cannot show. These are the number of ticks spent at each level over whole periods, the exact moment a buffered duty takes effect, the value returned on read-back, the polarity choice, and the behaviour of an absent channel.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic pol;
    logic center;
    logic en;
  } ctrl_t;

  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_CENTER_BIT = 1;
  localparam int CTRL_POL_BIT    = 2;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic         wr_per,
  input  logic         wr_duty,
  input  logic [W-1:0] wdata,
  input  logic         period_end,
  input  logic         restart,
  output ctrl_t        ctrl,
  output logic [W-1:0] per_sh,
  output logic [W-1:0] duty_sh,
  output logic [W-1:0] per_act,
  output logic [W-1:0] duty_act
);

  logic load_now;
  assign load_now = !ctrl.en || period_end || restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.en     <= wdata[CTRL_EN_BIT];
      ctrl.center <= wdata[CTRL_CENTER_BIT];
      ctrl.pol    <= wdata[CTRL_POL_BIT];
    end
  end

  // Shadow copies: always written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh  <= '0;
      duty_sh <= '0;
    end else begin
      if (wr_per)  per_sh  <= wdata;
      if (wr_duty) duty_sh <= wdata;
    end
  end

  // Active copies: direct write while disabled, otherwise load points only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act  <= '0;
      duty_act <= '0;
    end else begin
      if (wr_per && !ctrl.en)     per_act <= wdata;
      else if (load_now)          per_act <= per_sh;
      if (wr_duty && !ctrl.en)    duty_act <= wdata;
      else if (load_now)          duty_act <= duty_sh;
    end
  end

  // R4: active values hold between load points while running
  assert_active_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && $past(ctrl.en) && !$past(period_end) && !$past(restart))
      |-> ($stable(per_act) && $stable(duty_act)));

  // R6: a disabled channel leaves active equal to shadow one cycle later
  assert_disabled_copy_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> (per_act == per_sh && duty_act == duty_sh));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         center,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] per_act,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         period_end
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] nxt_cnt;
  logic         nxt_up;
  logic         wrap;
  logic [W-1:0] dec;

  assign dec = cnt - ONE;

  always_comb begin
    nxt_cnt = cnt;
    nxt_up  = up;
    wrap    = 1'b0;
    if (per_act == ZERO) begin
      nxt_cnt = ZERO;
      nxt_up  = 1'b1;
      wrap    = 1'b1;
    end else if (!center) begin
      nxt_up = 1'b1;
      if (cnt >= per_act - ONE) begin
        nxt_cnt = ZERO;
        wrap    = 1'b1;
      end else begin
        nxt_cnt = cnt + ONE;
      end
    end else if (up && cnt < per_act) begin
      nxt_cnt = cnt + ONE;
    end else begin
      nxt_cnt = dec;
      nxt_up  = 1'b0;
      if (dec == ZERO) begin
        nxt_up = 1'b1;
        wrap   = 1'b1;
      end
    end
  end

  assign period_end = en && tick && !restart && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
      up  <= 1'b1;
    end else if (!en || restart) begin
      cnt <= ZERO;
      up  <= 1'b1;
    end else if (tick) begin
      cnt <= nxt_cnt;
      up  <= nxt_up;
    end
  end

  assert_left_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (en && !center && per_act != ZERO) |-> (cnt < per_act));

  assert_center_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (en && center) |-> (cnt <= per_act));

  assert_restart_zero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == ZERO));

  assert_idle_zero_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == ZERO && up));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         center,
  input  logic         pol,
  input  logic         up,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] per_act,
  input  logic [W-1:0] duty_act,
  output logic         wave
);

  logic first_part;

  always_comb begin
    if (duty_act >= per_act)      first_part = 1'b1;
    else if (center && !up)       first_part = (cnt <= duty_act);
    else                          first_part = (cnt < duty_act);
  end

  assign wave = en ? (first_part ? pol : ~pol) : pol;

  // R3: edge-aligned output moves only at the duty match or the wrap
  assert_edge_points_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !center && !$past(center) && $stable(pol)
      && wave != $past(wave)) |-> (cnt == '0 || cnt == duty_act));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_chan_pkg::*;
#(
  parameter int W       = 8,
  parameter bit PRESENT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         pwm_out
);

  localparam int CTRL_W = $bits(ctrl_t);

  reg_sel_e     sel;
  logic         wr_ok, wr_ctrl, wr_per, wr_duty, wr_cnt;
  logic         mode_chg, restart, period_end, up, wave;
  ctrl_t        ctrl;
  logic [W-1:0] per_sh, duty_sh, per_act, duty_act, cnt;
  logic [W-1:0] rd_mux;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_ok   = reg_wr && PRESENT;
  assign wr_ctrl = wr_ok && sel == SEL_CTRL;
  assign wr_per  = wr_ok && sel == SEL_PER;
  assign wr_duty = wr_ok && sel == SEL_DUTY;
  assign wr_cnt  = wr_ok && sel == SEL_CNT;

  assign mode_chg = wr_ctrl && ctrl.en && reg_wdata[CTRL_EN_BIT]
                    && (reg_wdata[CTRL_CENTER_BIT] != ctrl.center);
  assign restart  = wr_cnt || mode_chg;

  pwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_per(wr_per),
    .wr_duty(wr_duty), .wdata(reg_wdata), .period_end(period_end),
    .restart(restart), .ctrl(ctrl), .per_sh(per_sh), .duty_sh(duty_sh),
    .per_act(per_act), .duty_act(duty_act)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .center(ctrl.center),
    .tick(tick), .restart(restart), .per_act(per_act), .cnt(cnt),
    .up(up), .period_end(period_end)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .center(ctrl.center),
    .pol(ctrl.pol), .up(up), .cnt(cnt), .per_act(per_act),
    .duty_act(duty_act), .wave(wave)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = {{(W-CTRL_W){1'b0}}, ctrl};
      SEL_PER:  rd_mux = per_sh;
      SEL_DUTY: rd_mux = duty_sh;
      default:  rd_mux = cnt;
    endcase
  end

  generate
    if (PRESENT) begin : g_present
      assign reg_rdata = rd_mux;
      assign pwm_out   = wave;
    end else begin : g_absent
      assign reg_rdata = '0;
      assign pwm_out   = 1'b0;
    end
  endgenerate

endmodule

// File: tb/test_pwm_channel.sv
module test_pwm_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 11;

  // {center, pol, period, duty, ticks observed, expected ticks at polarity level}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd5, 8'd2, 8'd5, 8'd2},   // R1 R12
    {1'b0, 1'b0, 8'd4, 8'd3, 8'd4, 8'd3},   // R1 R12 low-first
    {1'b0, 1'b1, 8'd6, 8'd0, 8'd6, 8'd0},   // R10 duty 0
    {1'b0, 1'b1, 8'd3, 8'd3, 8'd3, 8'd3},   // R10 duty = period
    {1'b0, 1'b0, 8'd3, 8'd9, 8'd3, 8'd3},   // R10 duty > period
    {1'b1, 1'b1, 8'd3, 8'd1, 8'd6, 8'd2},   // R2 R3
    {1'b1, 1'b0, 8'd4, 8'd2, 8'd8, 8'd4},   // R2 R3
    {1'b1, 1'b1, 8'd2, 8'd5, 8'd4, 8'd4},   // R2 R10
    {1'b0, 1'b1, 8'd0, 8'd4, 8'd8, 8'd8},   // R9 period 0
    {1'b1, 1'b1, 8'd1, 8'd0, 8'd2, 8'd0},   // R2 period 1
    {1'b0, 1'b1, 8'd1, 8'd1, 8'd1, 8'd1}    // R1 period 1
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_wr = 1'b0;
  logic [1:0]   reg_sel = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] rdata, rdata_abs;
  logic         pwm_out, out_abs;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_channel #(.W(W), .PRESENT(1'b1)) i_pwm_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .pwm_out(pwm_out));

  pwm_channel #(.W(W), .PRESENT(1'b0)) i_absent (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_abs), .pwm_out(out_abs));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    reg_sel = s;
    #1;
    v = int'(rdata);
  endtask

  task automatic step(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R7 reset read", v, 0);
    end
    chk("R11 reset output", int'(pwm_out), 0);

    // vector table: one whole period per entry
    for (int i = 0; i < NV; i++) begin
      logic c, p;
      logic [7:0] per, duty, len, exp;
      {c, p, per, duty, len, exp} = VEC[i];
      wr(2'd0, 8'd0);
      wr(2'd1, per);
      wr(2'd2, duty);
      wr(2'd0, {5'b0, p, c, 1'b1});
      tick = 1'b1;
      n = 0;
      for (int k = 0; k < int'(len); k++) begin
        #1;
        if (pwm_out == p) n++;
        @(negedge clk);
      end
      tick = 1'b0;
      chk(c ? "R2 R3 R12 level ticks" : "R1 R3 R12 level ticks", n, int'(exp));
      rd(2'd3, v);
      chk(c ? "R2 counter back at 0" : "R1 counter back at 0", v, 0);
    end

    // R4: buffered duty waits for the period end
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd4);
    wr(2'd2, 8'd1);
    wr(2'd0, 8'd5);            // enable, pol high, edge-aligned
    #1;
    chk("R6 disabled write active at cnt0", int'(pwm_out), 1);
    wr(2'd2, 8'd3);            // shadow only
    rd(2'd2, v);
    chk("R7 read returns shadow", v, 3);
    chk("R4 old duty at cnt0", int'(pwm_out), 1);
    step(1);                   // cnt 1
    chk("R4 old duty still active", int'(pwm_out), 0);
    step(3);                   // cnt 2,3,0 -> load
    step(1);                   // cnt 1
    chk("R4 new duty after period end", int'(pwm_out), 1);
    step(2);                   // cnt 3
    chk("R4 new duty match at 3", int'(pwm_out), 0);

    // R5: counter write resets and loads
    wr(2'd2, 8'd0);
    wr(2'd3, 8'hA5);
    rd(2'd3, v);
    chk("R5 counter write gives 0", v, 0);
    chk("R4 counter write loads duty 0", int'(pwm_out), 0);
    step(2);
    rd(2'd3, v);
    chk("R1 counter after two ticks", v, 2);
    wr(2'd3, 8'h00);
    rd(2'd3, v);
    chk("R5 counter write mid-count", v, 0);

    // R4/R11: disable loads the shadow
    wr(2'd2, 8'd2);
    wr(2'd0, 8'd4);            // disabled, pol high
    #1;
    chk("R11 disabled output at polarity", int'(pwm_out), 1);
    step(3);
    rd(2'd3, v);
    chk("R11 disabled counter held", v, 0);
    wr(2'd0, 8'd5);
    step(1);
    chk("R4 disable-loaded duty cnt1", int'(pwm_out), 1);
    step(1);
    chk("R4 disable-loaded duty cnt2", int'(pwm_out), 0);

    // R5: alignment change restarts
    wr(2'd0, 8'd7);
    rd(2'd3, v);
    chk("R5 mode change restarts counter", v, 0);
    rd(2'd0, v);
    chk("R7 control read back", v, 7);

    // R8: absent channel
    wr(2'd1, 8'd9);
    reg_sel = 2'd1;
    #1;
    chk("R8 absent reads zero", int'(rdata_abs), 0);
    chk("R8 absent output low", int'(out_abs), 0);
    chk("R7 present channel read", int'(rdata), 9);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule